// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned 6-bit operands and returns the exact 12-bit product. It accepts one operand pair per clock. A valid flag travels with each pair. The result appears five clocks after the pair is sampled, so a stream of back-to-back pairs produces a stream of back-to-back products with no gaps.

Inside the block, the first stage forms one shifted partial-product row per multiplier bit. Three stages of 3:2 carry-save compression follow, taking the rows from six to four, then to three, then to two. The last stage is a ripple carry-propagate adder that resolves the remaining pair of vectors into the product. Each stage is registered. Data registers only load when a valid item enters them. The product output therefore keeps the last valid result until a newer valid one arrives.

Top module: `csa_pipe_mul`

## Requirements
- R1: The first stage forms six 12-bit rows; row i equals the multiplicand ANDed with multiplier bit i and shifted left by i, so its bits below position i are zero and the rows sum to the full product.
- R2: For every accepted pair, out_product equals in_a times in_b as an unsigned 12-bit value.
- R3: out_valid is high exactly on the fifth rising edge after the edge that sampled in_valid high, counting the sampling edge as the first.
- R4: Pairs presented on consecutive clocks produce products on consecutive clocks, in the same order (throughput of one per clock).
- R5: While rst_n is low at a rising edge, all in-flight valid flags are cleared and out_product is set to zero at that edge.
- R6: Operands with in_valid low are ignored: they produce no out_valid pulse, and out_product holds its previous value in any cycle where no valid item reaches the output.
- R7: Each carry-save stage preserves the exact arithmetic sum of its rows, and no carry is lost off the top of the 12-bit vectors.
- R8: The operand extremes (0 and 63 on either side) give exact products, including 63 times 63 = 3969.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies in_a and in_b in this cycle |
| in_a | input | 6 | Unsigned multiplicand |
| in_b | input | 6 | Unsigned multiplier |
| out_valid | output | 1 | Qualifies out_product in this cycle |
| out_product | output | 12 | Unsigned product |

## Verification
The assertions check several things on every cycle:
- each carry-save stage carries forward the exact arithmetic total of the rows it received;
- the partial-product rows are aligned, and their sum matches the product of the sampled operands;
- the valid flag advances one stage per clock;
- the output holds while nothing valid arrives;
- reset clears the valid flags and the product.

Correct ordering of results, gaps in the input stream, extreme operands and a reset that lands on a full pipeline are shown only by the bench scenarios. Those scenarios cover an exhaustive back-to-back sweep of all 4096 pairs, sparse corner pairs with garbage operands between them, and a mid-stream reset. Each one is compared against a behavioural latency model every clock.

// File: rtl/csa_mul_pkg.sv
// Package: csa_mul_pkg
// Shared sizing and row type for the carry-save multiplier pipeline.
// Assumes unsigned operands of equal width. The reduction tree is fixed at
// six rows, so the operand width must stay at six.
package csa_mul_pkg;
    localparam int OP_W    = 6;
    localparam int PROD_W  = 2 * OP_W;
    localparam int ROWS_S1 = OP_W;      // partial-product rows
    localparam int ROWS_S2 = 4;         // after two parallel 3:2 compressors
    localparam int ROWS_S3 = 3;         // after one 3:2 compressor plus pass-through
    localparam int ROWS_S4 = 2;         // sum and carry vectors
    localparam int LATENCY = 5;

    typedef logic [PROD_W-1:0] row_t;
endpackage

// File: rtl/csa_ppgen.sv
// Module: csa_ppgen
// Purely combinational partial-product generator. Row i is the multiplicand
// gated by multiplier bit i and shifted left by i, zero-extended to RES_W.
// Assumes RES_W >= 2*OPW so no shifted bit is lost.
module csa_ppgen #(
    parameter int OPW   = 6,
    parameter int RES_W = 12
) (
    input  logic                       [OPW-1:0]   mcand,
    input  logic                       [OPW-1:0]   mplier,
    output logic [OPW-1:0][RES_W-1:0]              rows
);
    localparam int PAD_W = RES_W - OPW;

    genvar gi;
    generate
        for (gi = 0; gi < OPW; gi++) begin : g_row
            // One shifted, gated copy of the multiplicand per multiplier bit
            assign rows[gi] = {{PAD_W{1'b0}}, (mcand & {OPW{mplier[gi]}})} << gi;
        end
    endgenerate
endmodule

// File: rtl/csa_3to2.sv
// Module: csa_3to2
// Combinational carry-save adder: three W-bit vectors in, a sum vector and a
// left-shifted carry vector out, with no carry rippling between positions.
// Assumes the caller's total fits in W bits, so the carry shifted out of the
// top position is always zero.
module csa_3to2 #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    logic [W-1:0] maj;

    // Bitwise full-adder sum and majority, carries moved up one place
    always_comb begin
        sum   = x ^ y ^ z;
        maj   = (x & y) | (x & z) | (y & z);
        carry = maj << 1;
    end
endmodule

// File: rtl/csa_ripple_cpa.sv
// Module: csa_ripple_cpa
// Combinational ripple carry-propagate adder for the final two vectors.
// Assumes the true sum fits in W bits; the carry out of the top is discarded.
module csa_ripple_cpa #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] c;

    assign c[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Sum bit of one full adder cell
            assign s[gi] = a[gi] ^ b[gi] ^ c[gi];
            if (gi < W - 1) begin : g_carry
                // Carry into the next cell
                assign c[gi+1] = (a[gi] & b[gi]) | (a[gi] & c[gi]) | (b[gi] & c[gi]);
            end
        end
    endgenerate
endmodule

// File: rtl/csa_pipe_mul.sv
// Module: csa_pipe_mul
// Five-stage unsigned multiplier:
//   stage 1 partial products (6 rows)
//   stage 2 6->4 rows
//   stage 3 4->3 rows
//   stage 4 3->2 rows
//   stage 5 carry-propagate add
// Assumes one pair per clock and no backpressure. Valid flags are cleared by
// synchronous active-low reset; data registers load only with a valid item,
// and the product output holds between valid results.
module csa_pipe_mul
    import csa_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_product
);
    logic [LATENCY-1:0]         vld;
    logic                       s1_valid, s2_valid, s3_valid, s4_valid;

    row_t [ROWS_S1-1:0]         pp_rows;
    row_t [ROWS_S1-1:0]         s1_rows;
    row_t [ROWS_S2-1:0]         s2_next, s2_rows;
    row_t [ROWS_S3-1:0]         s3_next, s3_rows;
    row_t [ROWS_S4-1:0]         s4_next, s4_rows;
    row_t                       cpa_sum;

    assign s1_valid  = vld[0];
    assign s2_valid  = vld[1];
    assign s3_valid  = vld[2];
    assign s4_valid  = vld[3];
    assign out_valid = vld[4];

    // Valid flag shift chain, one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else        vld <= {vld[LATENCY-2:0], in_valid};
    end

    // Stage 1: partial-product rows
    csa_ppgen #(.OPW(OP_W), .RES_W(PROD_W)) u_ppgen (
        .mcand  (in_a),
        .mplier (in_b),
        .rows   (pp_rows)
    );

    // Capture partial products for a valid pair
    always_ff @(posedge clk) begin
        if (in_valid) s1_rows <= pp_rows;
    end

    // Stage 2: two compressors in parallel, six rows to four
    csa_3to2 #(.W(PROD_W)) u_csa2_lo (
        .x(s1_rows[0]), .y(s1_rows[1]), .z(s1_rows[2]),
        .sum(s2_next[0]), .carry(s2_next[1])
    );
    csa_3to2 #(.W(PROD_W)) u_csa2_hi (
        .x(s1_rows[3]), .y(s1_rows[4]), .z(s1_rows[5]),
        .sum(s2_next[2]), .carry(s2_next[3])
    );

    // Capture the four stage-2 rows
    always_ff @(posedge clk) begin
        if (s1_valid) s2_rows <= s2_next;
    end

    // Stage 3: one compressor, fourth row bypasses
    csa_3to2 #(.W(PROD_W)) u_csa3 (
        .x(s2_rows[0]), .y(s2_rows[1]), .z(s2_rows[2]),
        .sum(s3_next[0]), .carry(s3_next[1])
    );
    assign s3_next[2] = s2_rows[3];

    // Capture the three stage-3 rows
    always_ff @(posedge clk) begin
        if (s2_valid) s3_rows <= s3_next;
    end

    // Stage 4: final compressor leaves a sum and a carry vector
    csa_3to2 #(.W(PROD_W)) u_csa4 (
        .x(s3_rows[0]), .y(s3_rows[1]), .z(s3_rows[2]),
        .sum(s4_next[0]), .carry(s4_next[1])
    );

    // Capture the two stage-4 vectors
    always_ff @(posedge clk) begin
        if (s3_valid) s4_rows <= s4_next;
    end

    // Stage 5: carry-propagate addition
    csa_ripple_cpa #(.W(PROD_W)) u_cpa (
        .a(s4_rows[0]),
        .b(s4_rows[1]),
        .s(cpa_sum)
    );

    // Product register: cleared by reset, loads only with a valid result
    always_ff @(posedge clk) begin
        if (!rst_n)        out_product <= '0;
        else if (s4_valid) out_product <= cpa_sum;
    end
endmodule

// File: rtl/csa_pipe_mul_chk.sv
// Module: csa_pipe_mul_chk
// Assertion checker bound into csa_pipe_mul. It watches:
//   - the valid chain, one stage per clock
//   - the exact arithmetic sum carried from stage to stage
//   - alignment of the partial-product rows
//   - reset behaviour
//   - output hold when no valid result arrives
// Sums are taken three bits wider than a row so that a dropped top carry
// shows up as a mismatch.
module csa_pipe_mul_chk
    import csa_mul_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [OP_W-1:0]               in_a,
    input logic [OP_W-1:0]               in_b,
    input logic                          s1_valid,
    input logic                          s2_valid,
    input logic                          s3_valid,
    input logic                          s4_valid,
    input logic                          out_valid,
    input logic [ROWS_S1-1:0][PROD_W-1:0] s1_rows,
    input logic [ROWS_S2-1:0][PROD_W-1:0] s2_rows,
    input logic [ROWS_S3-1:0][PROD_W-1:0] s3_rows,
    input logic [ROWS_S4-1:0][PROD_W-1:0] s4_rows,
    input logic [PROD_W-1:0]             out_product
);
    localparam int SW = PROD_W + 3;

    function automatic logic [SW-1:0] sum6(input logic [ROWS_S1-1:0][PROD_W-1:0] r);
        logic [SW-1:0] acc = '0;
        for (int i = 0; i < ROWS_S1; i++) acc = acc + SW'(r[i]);
        return acc;
    endfunction

    function automatic logic [SW-1:0] sum4(input logic [ROWS_S2-1:0][PROD_W-1:0] r);
        logic [SW-1:0] acc = '0;
        for (int i = 0; i < ROWS_S2; i++) acc = acc + SW'(r[i]);
        return acc;
    endfunction

    function automatic logic [SW-1:0] sum3(input logic [ROWS_S3-1:0][PROD_W-1:0] r);
        logic [SW-1:0] acc = '0;
        for (int i = 0; i < ROWS_S3; i++) acc = acc + SW'(r[i]);
        return acc;
    endfunction

    function automatic logic [SW-1:0] sum2(input logic [ROWS_S4-1:0][PROD_W-1:0] r);
        return SW'(r[0]) + SW'(r[1]);
    endfunction

    // R1: captured rows add up to the sampled operands' product
    assert_pp_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sum6(s1_rows) == (SW'($past(in_a)) * SW'($past(in_b)))));

    genvar gi;
    generate
        for (gi = 1; gi < ROWS_S1; gi++) begin : g_align
            // R1: row gi carries no bits below position gi
            assert_row_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
                s1_valid |-> ((s1_rows[gi] & PROD_W'((1 << gi) - 1)) == '0));
        end
    endgenerate

    // R3: valid advances one stage per clock
    assert_valid_s1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    assert_valid_s2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> s2_valid);
    assert_valid_s3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> s3_valid);
    assert_valid_s4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s3_valid |=> s4_valid);
    assert_valid_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s4_valid |=> out_valid);
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !s4_valid |=> !out_valid);

    // R7: each compression stage keeps the exact total
    assert_sum_s2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (sum4(s2_rows) == $past(sum6(s1_rows))));
    assert_sum_s3_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> (sum3(s3_rows) == $past(sum4(s2_rows))));
    assert_sum_s4_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s3_valid |=> (sum2(s4_rows) == $past(sum3(s3_rows))));

    // R2: the carry-propagate result equals the two-vector total
    assert_cpa_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s4_valid |=> (SW'(out_product) == $past(sum2(s4_rows))));

    // R6: output holds when no valid result arrives
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s4_valid |=> $stable(out_product));

    // R5: synchronous reset clears the output
    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_product == '0)));
endmodule

bind csa_pipe_mul csa_pipe_mul_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .s1_valid    (s1_valid),
    .s2_valid    (s2_valid),
    .s3_valid    (s3_valid),
    .s4_valid    (s4_valid),
    .out_valid   (out_valid),
    .s1_rows     (s1_rows),
    .s2_rows     (s2_rows),
    .s3_rows     (s3_rows),
    .s4_rows     (s4_rows),
    .out_product (out_product)
);

// File: tb/csa_pipe_mul_bench.sv
// Bench: csa_pipe_mul_bench
// Behavioural latency model, updated and compared every clock at the
// falling edge. Scenarios:
//   - reset state
//   - exhaustive back-to-back sweep
//   - sparse corner pairs with garbage operands between them
//   - mid-stream reset
module csa_pipe_mul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_a = '0;
    logic [5:0]  in_b = '0;
    logic        out_valid;
    logic [11:0] out_product;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Model state: valid and product per stage, plus expected outputs
    int  mv[4];
    int  mp[4];
    int  m_ov = 0;
    int  m_op = 0;
    string cur_req = "R5";

    csa_pipe_mul u_csa_pipe_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_product (out_product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cycles++;

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    // Compare outputs, drive the next inputs, advance the model past one edge
    task automatic step(input logic v, input int a, input int b, input logic r);
        chk("out_valid", int'(out_valid), m_ov);
        chk("out_product", int'(out_product), m_op);
        in_valid = v;
        in_a     = a[5:0];
        in_b     = b[5:0];
        rst_n    = r;
        if (!r) begin
            for (int i = 0; i < 4; i++) mv[i] = 0;
            m_ov = 0;
            m_op = 0;
        end else begin
            m_ov = mv[3];
            if (mv[3] != 0) m_op = mp[3];
            for (int i = 3; i > 0; i--) begin
                mv[i] = mv[i-1];
                mp[i] = mp[i-1];
            end
            mv[0] = int'(v);
            mp[0] = (a % 64) * (b % 64);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, int'($urandom % 64), int'($urandom % 64), 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mv[i] = 0; mp[i] = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk);

        // R5: reset state, held for a few cycles
        cur_req = "R5";
        for (int k = 0; k < 3; k++) step(1'b0, 0, 0, 1'b0);

        // R6: garbage operands with valid low must not appear
        cur_req = "R6";
        idle(8);

        // R2 R4 R1: exhaustive back-to-back sweep
        cur_req = "R2/R4";
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                step(1'b1, a, b, 1'b1);
        cur_req = "R3";
        idle(6);

        // R8: corner pairs separated by idle gaps (R6 hold in the gaps)
        cur_req = "R8";
        step(1'b1, 63, 63, 1'b1); idle(3);
        step(1'b1, 0, 63, 1'b1);  idle(7);
        step(1'b1, 63, 0, 1'b1);  idle(1);
        step(1'b1, 63, 1, 1'b1);
        step(1'b1, 1, 63, 1'b1);  idle(2);
        step(1'b1, 32, 32, 1'b1);
        step(1'b1, 42, 21, 1'b1);
        cur_req = "R6";
        idle(9);

        // R5: reset lands on a full pipeline, then traffic resumes
        cur_req = "R5";
        for (int k = 0; k < 4; k++) step(1'b1, 50 + k, 60 - k, 1'b1);
        step(1'b1, 9, 9, 1'b0);
        idle(6);
        cur_req = "R3";
        step(1'b1, 7, 11, 1'b1);
        idle(7);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule